// File: doc/BRIEF.md
# Cache Tag Maintenance Engine

This block holds the tag store of a four-way set-associative cache and carries out maintenance commands over a run of consecutive cache lines. A command names an operation, a start address and a number of lines. The engine rounds the start address down to a line boundary and visits one line at a time. For each line it reads the tag entries of all four ways in the selected set, picks the way that hits, and rewrites that entry. Invalidate, clean, lock and unlock each change one bit. Writeback asks a data-side port to copy out a dirty line and waits for that port's acknowledge. A separate command clears the valid bit of every entry in the array.

The geometry is chosen at run time: the line is 16 or 32 bytes, and the capacity is 8 or 16 KB. These settings fix how an address divides into set index and tag. A fill port writes complete entries and a readout port returns them. The line fill path and the CPU lookup path use these ports, and the bench uses them too.

Top module: `ctag_maint`

## Requirements
- R1: A tag entry is a 32-bit word. Its fields are: bit 0 dirty, bits 14:1 tag, bit 15 valid, bits 18:16 age, bit 19 lock, bits 22:20 attribute, bit 23 access, bits 31:24 spare. Maintenance changes only the field its operation names and leaves every other bit as it was.
- R2: `line_sel` 0 gives 16-byte lines and 1 gives 32-byte lines. `size_sel` 0 gives 8 KB and 1 gives 16 KB. Let lb be log2(line) and ib be log2(size)-2. An address whose bits 31:22 equal 0x0F0 lies in the window. Its set is bits ib-1:lb and its tag is bits 21:ib. A line outside the window changes nothing.
- R3: A ranged command rounds the start address down to the line size and visits exactly `cmd_items` consecutive lines. A count of zero does nothing and never raises busy.
- R4: Op code 1 (invalidate) clears valid on the hit way unless that entry is locked.
- R5: Op code 2 (clean) clears dirty on the hit way and makes no data-port request.
- R6: For op code 3 (writeback), each dirty hit raises `wb_req` with the line address and the hit way. The request stays steady until `wb_ack`, and then dirty is cleared. A hit that is not dirty makes no request.
- R7: Op codes 4 (lock) and 5 (unlock) set and clear the lock bit on the hit way.
- R8: Op code 6 (invalidate all) clears valid in all four ways of every set that the current geometry uses, including locked entries.
- R9: When several ways hold a valid entry with a matching tag, only the lowest-numbered way is changed.
- R10: Busy rises on the edge that accepts a command. Without writeback waits it stays high for exactly two cycles per line visited; invalidate-all visits one set per step.
- R11: A command offered while busy is dropped and `err_o` pulses high for one cycle. Op codes 0 and 7 are dropped and do not raise busy.
- R12: After reset, `busy_o`, `err_o` and `wb_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sel | input | 1 | Line size select (0: 16 B, 1: 32 B) |
| size_sel | input | 1 | Capacity select (0: 8 KB, 1: 16 KB) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 32 | Start address |
| cmd_items | input | 19 | Number of lines |
| busy_o | output | 1 | A command is running |
| err_o | output | 1 | One-cycle pulse when a command is dropped because the engine is busy |
| wb_req | output | 1 | Writeback request to the data side |
| wb_addr | output | 32 | Line address of the writeback |
| wb_way | output | 2 | Way of the writeback |
| wb_ack | input | 1 | Data side has finished the writeback |
| tw_en | input | 1 | Entry write strobe; accepted only while idle |
| tw_set | input | 8 | Set index of the entry write |
| tw_way | input | 2 | Way of the entry write |
| tw_data | input | 32 | Entry value to write |
| tr_en | input | 1 | Entry read strobe |
| tr_set | input | 8 | Set index of the entry read |
| tr_way | input | 2 | Way of the entry read |
| tr_data | output | 32 | Entry value, valid the cycle after `tr_en` |

## Verification
The stimulus mixes entries seeded at random around a random range with random operations across all four geometries. Mixing them this way separates wrong set or tag slicing from wrong per-operation field updates. Directed cases each isolate one concern:
- A range that runs off the top of the window, which exposes a missing window check.
- An unaligned start and a zero count, which show alignment and count errors.
- A locked entry under invalidate.
- Duplicate tags in two ways, which test way priority.
- A command issued while another is running.

Writeback runs with random acknowledge delays, so both the request order and its hold behaviour are exercised. The bench compares the whole array after every command, so any stray write to an unrelated entry is caught.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int TAG_W = 14;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_INVAL  = 3'd1,
    OP_CLEAN  = 3'd2,
    OP_WBACK  = 3'd3,
    OP_LOCK   = 3'd4,
    OP_UNLOCK = 3'd5,
    OP_INVALL = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CMP, S_WB} st_e;

  // first member is the MSB: spare bits on top, dirty in bit 0
  typedef struct packed {
    logic [7:0]       spare;
    logic             access;
    logic [2:0]       attr;
    logic             lock;
    logic [2:0]       age;
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic             dirty;
  } tag_ent_t;
endpackage

// File: rtl/ctag_way_ram.sv
module ctag_way_ram #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SET_W-1:0] waddr,
  input  logic [31:0]      wdata,
  input  logic [SET_W-1:0] ra_addr,
  output logic [31:0]      ra_q,
  input  logic             rb_en,
  input  logic [SET_W-1:0] rb_addr,
  output logic [31:0]      rb_q
);
  localparam int DEPTH = 1 << SET_W;
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_q <= mem[ra_addr];
    if (rb_en) rb_q <= mem[rb_addr];
  end
endmodule

// File: rtl/ctag_addr_split.sv
module ctag_addr_split #(
  parameter logic [31:0] WIN_BASE      = 32'h3C00_0000,
  parameter int          WIN_LOG2      = 22,
  parameter int          MAX_SIZE_LOG2 = 14,
  parameter int          MIN_LINE_LOG2 = 4,
  parameter int          SET_W         = 8,
  parameter int          TAG_W         = 14
) (
  input  logic [31:0]      addr,
  input  logic             line_sel,
  input  logic             size_sel,
  output logic             in_win,
  output logic [SET_W-1:0] set_idx,
  output logic [TAG_W-1:0] tag
);
  logic [WIN_LOG2-1:0] off;
  logic [WIN_LOG2-1:0] smask;
  int lb, ib;

  always_comb begin
    lb      = MIN_LINE_LOG2 + (line_sel ? 1 : 0);
    ib      = MAX_SIZE_LOG2 - 2 - (size_sel ? 0 : 1);
    off     = addr[WIN_LOG2-1:0];
    smask   = (WIN_LOG2'(1) << (ib - lb)) - WIN_LOG2'(1);
    set_idx = SET_W'((off >> lb) & smask);
    tag     = TAG_W'(off >> ib);
    in_win  = (addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]);
  end
endmodule

// File: rtl/ctag_maint.sv
module ctag_maint
  import ctag_pkg::*;
#(
  parameter logic [31:0] WIN_BASE      = 32'h3C00_0000,
  parameter int          WIN_LOG2      = 22,
  parameter int          MAX_SIZE_LOG2 = 14,
  parameter int          MIN_LINE_LOG2 = 4,
  localparam int         SET_W         = MAX_SIZE_LOG2 - 2 - MIN_LINE_LOG2,
  localparam int         CNT_W         = WIN_LOG2 - MIN_LINE_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_sel,
  input  logic             size_sel,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [31:0]      cmd_addr,
  input  logic [CNT_W-1:0] cmd_items,
  output logic             busy_o,
  output logic             err_o,
  output logic             wb_req,
  output logic [31:0]      wb_addr,
  output logic [WAY_W-1:0] wb_way,
  input  logic             wb_ack,
  input  logic             tw_en,
  input  logic [SET_W-1:0] tw_set,
  input  logic [WAY_W-1:0] tw_way,
  input  logic [31:0]      tw_data,
  input  logic             tr_en,
  input  logic [SET_W-1:0] tr_set,
  input  logic [WAY_W-1:0] tr_way,
  output logic [31:0]      tr_data
);
  st_e              st;
  op_e              op;
  logic [31:0]      cur_addr;
  logic [CNT_W-1:0] left;
  logic [SET_W-1:0] all_set, lat_set, rd_set, s_set;
  logic [TAG_W-1:0] lat_tag, s_tag;
  logic             lat_in, s_in, m_line, m_size;
  tag_ent_t         wb_ent;
  logic [WAY_W-1:0] tr_way_q;

  logic [31:0]      ra_q [WAYS];
  logic [31:0]      rb_q [WAYS];
  tag_ent_t         q    [WAYS];
  tag_ent_t         eng_wd [WAYS];
  logic [WAYS-1:0]  eng_we;
  logic             hit_any;
  logic [WAY_W-1:0] hway;
  logic             legal, start;
  logic [31:0]      lmask_m, lbytes_m;

  function automatic logic [CNT_W-1:0] set_count(input logic ls, input logic ss);
    int sb;
    sb = (MAX_SIZE_LOG2 - 2 - (ss ? 0 : 1)) - (MIN_LINE_LOG2 + (ls ? 1 : 0));
    return CNT_W'(1) << sb;
  endfunction

  ctag_addr_split #(
    .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .MAX_SIZE_LOG2(MAX_SIZE_LOG2),
    .MIN_LINE_LOG2(MIN_LINE_LOG2), .SET_W(SET_W), .TAG_W(TAG_W)
  ) u_split (
    .addr(cur_addr), .line_sel(m_line), .size_sel(m_size),
    .in_win(s_in), .set_idx(s_set), .tag(s_tag)
  );

  assign busy_o   = (st != S_IDLE);
  assign rd_set   = (op == OP_INVALL) ? all_set : s_set;
  assign lbytes_m = 32'(1) << (MIN_LINE_LOG2 + (m_line ? 1 : 0));
  assign lmask_m  = lbytes_m - 32'd1;
  assign legal    = (cmd_op != OP_NONE) && (cmd_op != OP_RSVD);
  assign start    = cmd_valid && legal && (st == S_IDLE) &&
                    ((cmd_op == OP_INVALL) || (cmd_items != '0));

  // tag store: one memory per way, all read in the same cycle
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic             we_m;
    logic [SET_W-1:0] wa_m;
    logic [31:0]      wd_m;
    assign we_m = eng_we[w] | (tw_en && (st == S_IDLE) && (tw_way == WAY_W'(w)));
    assign wa_m = (st == S_IDLE) ? tw_set : lat_set;
    assign wd_m = (st == S_IDLE) ? tw_data : eng_wd[w];
    assign q[w] = tag_ent_t'(ra_q[w]);
    ctag_way_ram #(.SET_W(SET_W)) u_ram (
      .clk(clk), .we(we_m), .waddr(wa_m), .wdata(wd_m),
      .ra_addr(rd_set), .ra_q(ra_q[w]),
      .rb_en(tr_en), .rb_addr(tr_set), .rb_q(rb_q[w])
    );
  end

  assign tr_data = rb_q[tr_way_q];

  // hit selection: lowest way wins
  always_comb begin
    hit_any = 1'b0;
    hway    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lat_in && q[w].valid && (q[w].tag == lat_tag)) begin
        hit_any = 1'b1;
        hway    = WAY_W'(w);
      end
    end
  end

  // entry update per way
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      eng_we[w] = 1'b0;
      eng_wd[w] = q[w];
      if (st == S_CMP) begin
        if (op == OP_INVALL) begin
          eng_we[w]       = 1'b1;
          eng_wd[w].valid = 1'b0;
        end else if (hit_any && (hway == WAY_W'(w))) begin
          case (op)
            OP_INVAL:  if (!q[w].lock) begin eng_we[w] = 1'b1; eng_wd[w].valid = 1'b0; end
            OP_CLEAN:  begin eng_we[w] = 1'b1; eng_wd[w].dirty = 1'b0; end
            OP_LOCK:   begin eng_we[w] = 1'b1; eng_wd[w].lock  = 1'b1; end
            OP_UNLOCK: begin eng_we[w] = 1'b1; eng_wd[w].lock  = 1'b0; end
            default:   ;
          endcase
        end
      end else if ((st == S_WB) && wb_ack && (wb_way == WAY_W'(w))) begin
        eng_we[w]       = 1'b1;
        eng_wd[w]       = wb_ent;
        eng_wd[w].dirty = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tr_en) tr_way_q <= tr_way;
    if (rst) begin
      st       <= S_IDLE;
      op       <= OP_NONE;
      err_o    <= 1'b0;
      wb_req   <= 1'b0;
      wb_addr  <= '0;
      wb_way   <= '0;
      wb_ent   <= '0;
      cur_addr <= '0;
      left     <= '0;
      all_set  <= '0;
      lat_set  <= '0;
      lat_tag  <= '0;
      lat_in   <= 1'b0;
      m_line   <= 1'b0;
      m_size   <= 1'b0;
    end else begin
      err_o <= cmd_valid && (st != S_IDLE);
      case (st)
        S_IDLE: if (start) begin
          op       <= op_e'(cmd_op);
          m_line   <= line_sel;
          m_size   <= size_sel;
          cur_addr <= cmd_addr & ~((32'(1) << (MIN_LINE_LOG2 + (line_sel ? 1 : 0))) - 32'd1);
          left     <= (cmd_op == OP_INVALL) ? set_count(line_sel, size_sel) : cmd_items;
          all_set  <= '0;
          st       <= S_READ;
        end
        S_READ: begin
          lat_set <= rd_set;
          lat_tag <= s_tag;
          lat_in  <= s_in;
          st      <= S_CMP;
        end
        S_CMP: begin
          if ((op == OP_WBACK) && hit_any && q[hway].dirty) begin
            wb_req  <= 1'b1;
            wb_addr <= cur_addr;
            wb_way  <= hway;
            wb_ent  <= q[hway];
            st      <= S_WB;
          end else begin
            left     <= left - CNT_W'(1);
            cur_addr <= cur_addr + lbytes_m;
            all_set  <= all_set + SET_W'(1);
            st       <= (left == CNT_W'(1)) ? S_IDLE : S_READ;
          end
        end
        S_WB: if (wb_ack) begin
          wb_req   <= 1'b0;
          left     <= left - CNT_W'(1);
          cur_addr <= cur_addr + lbytes_m;
          st       <= (left == CNT_W'(1)) ? S_IDLE : S_READ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(busy_o)); // R11
  AST_WB_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_way))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !wb_req); // R10
  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ((st == S_READ) && (op != OP_INVALL)) |-> ((cur_addr & lmask_m) == 32'd0)); // R3
endmodule

// File: tb/ctag_maint_test.sv
module ctag_maint_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_sel = 1'b0, size_sel = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_addr = '0;
  logic [18:0] cmd_items = '0;
  logic        busy_o, err_o, wb_req, wb_ack = 1'b0;
  logic [31:0] wb_addr;
  logic [1:0]  wb_way;
  logic        tw_en = 1'b0, tr_en = 1'b0;
  logic [7:0]  tw_set = '0, tr_set = '0;
  logic [1:0]  tw_way = '0, tr_way = '0;
  logic [31:0] tw_data = '0;
  logic [31:0] tr_data;

  int total = 0, fails = 0, cyc = 0;
  logic [31:0] mdl [0:3][0:255];
  logic [31:0] exp_wb [0:1023];
  logic [1:0]  exp_way [0:1023];
  int n_exp;

  always #10 clk = ~clk;

  ctag_maint uut (
    .clk(clk), .rst(rst), .line_sel(line_sel), .size_sel(size_sel),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_items(cmd_items),
    .busy_o(busy_o), .err_o(err_o), .wb_req(wb_req), .wb_addr(wb_addr), .wb_way(wb_way),
    .wb_ack(wb_ack), .tw_en(tw_en), .tw_set(tw_set), .tw_way(tw_way), .tw_data(tw_data),
    .tr_en(tr_en), .tr_set(tr_set), .tr_way(tr_way), .tr_data(tr_data)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; total++;
      $display("FAIL watchdog R10 actual %0d expected < 190000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // address geometry from R2
  function automatic int lb_of(); return 4 + int'(line_sel); endfunction
  function automatic int ib_of(); return (size_sel ? 14 : 13) - 2; endfunction
  function automatic bit in_win(input logic [31:0] a); return a[31:22] == 10'h0F0; endfunction
  function automatic int set_of(input logic [31:0] a);
    return int'((a[21:0] >> lb_of()) & ((22'd1 << (ib_of() - lb_of())) - 22'd1));
  endfunction
  function automatic logic [13:0] tag_of(input logic [31:0] a);
    return 14'(a[21:0] >> ib_of());
  endfunction
  function automatic logic [31:0] mk(input logic [13:0] t, input bit v, input bit d,
                                     input bit lk, input logic [2:0] age);
    logic [7:0] sp; logic [2:0] at; logic ac;
    sp = 8'($urandom); at = 3'($urandom); ac = 1'($urandom);
    return {sp, ac, at, lk, age, v, t, d}; // R1 field layout
  endfunction

  task automatic put(input int s, input int w, input logic [31:0] e);
    @(negedge clk);
    tw_en = 1'b1; tw_set = 8'(s); tw_way = 2'(w); tw_data = e;
    mdl[w][s] = e;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic put_addr(input logic [31:0] a, input int w, input bit v, input bit d, input bit lk);
    put(set_of(a), w, mk(tag_of(a), v, d, lk, 3'(w)));
  endtask

  // reference model of one command, R3..R9
  task automatic model(input int op, input logic [31:0] addr, input int items);
    logic [31:0] a; int s, hw, lbytes;
    n_exp = 0;
    lbytes = 1 << lb_of();
    if (op == 6) begin
      for (int ss = 0; ss < (1 << (ib_of() - lb_of())); ss++)
        for (int w = 0; w < 4; w++) mdl[w][ss][15] = 1'b0;
      return;
    end
    if (op == 0 || op == 7) return;
    a = addr & ~32'(lbytes - 1);
    for (int i = 0; i < items; i++) begin
      if (in_win(a)) begin
        s = set_of(a); hw = -1;
        for (int w = 3; w >= 0; w--)
          if (mdl[w][s][15] && mdl[w][s][14:1] == tag_of(a)) hw = w;
        if (hw >= 0) begin
          case (op)
            1: if (!mdl[hw][s][19]) mdl[hw][s][15] = 1'b0;
            2: mdl[hw][s][0] = 1'b0;
            3: if (mdl[hw][s][0]) begin
                 exp_wb[n_exp] = a; exp_way[n_exp] = 2'(hw); n_exp++;
                 mdl[hw][s][0] = 1'b0;
               end
            4: mdl[hw][s][19] = 1'b1;
            5: mdl[hw][s][19] = 1'b0;
            default: ;
          endcase
        end
      end
      a = a + 32'(lbytes);
    end
  endtask

  task automatic run_cmd(input int op, input logic [31:0] addr, input int items, input string rq);
    int busy_cyc, seen, d;
    model(op, addr, items);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = addr; cmd_items = 19'(items);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_cyc = 0; seen = 0;
    while (busy_o) begin
      if (wb_req && !wb_ack) begin
        check(seen < n_exp, "R6 extra writeback", wb_addr, 32'(n_exp));
        if (seen < n_exp) begin
          check(wb_addr === exp_wb[seen], "R6 writeback address", wb_addr, exp_wb[seen]);
          check(wb_way === exp_way[seen], "R6 writeback way", 32'(wb_way), 32'(exp_way[seen]));
        end
        seen++;
        d = $urandom % 4;
        repeat (d) begin @(negedge clk); busy_cyc++; end
        wb_ack = 1'b1;
      end else wb_ack = 1'b0;
      @(negedge clk);
      busy_cyc++;
    end
    wb_ack = 1'b0;
    if (op == 3) check(seen == n_exp, "R6 writeback count", 32'(seen), 32'(n_exp));
    if (op == 6) check(busy_cyc == 2 * (1 << (ib_of() - lb_of())), "R10 busy length all",
                       32'(busy_cyc), 32'(2 * (1 << (ib_of() - lb_of()))));
    else if (op >= 1 && op <= 5 && op != 3)
      check(busy_cyc == 2 * items, {"R10 busy length ", rq}, 32'(busy_cyc), 32'(2 * items));
  endtask

  task automatic cmp_all(input string rq);
    int bad = 0, w, s;
    for (int i = 0; i <= 1024; i++) begin
      @(negedge clk);
      if (i > 0) begin
        w = (i - 1) / 256; s = (i - 1) % 256;
        if (tr_data !== mdl[w][s]) begin
          if (bad < 3) $display("FAIL %s R1 entry way %0d set %0d actual %h expected %h",
                                rq, w, s, tr_data, mdl[w][s]);
          bad++;
        end
      end
      if (i < 1024) begin tr_en = 1'b1; tr_way = 2'(i / 256); tr_set = 8'(i % 256); end
      else tr_en = 1'b0;
    end
    total++;
    if (bad != 0) fails++;
  endtask

  initial begin
    logic [31:0] a, st_a;
    int items, op, lbytes;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(busy_o === 1'b0 && err_o === 1'b0 && wb_req === 1'b0, "R12 reset outputs",
          {29'd0, busy_o, err_o, wb_req}, 32'd0);
    rst = 1'b0;
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 256; s++) put(s, w, 32'd0);

    // R2: range runs off the top of the window
    line_sel = 1'b0; size_sel = 1'b1;
    put_addr(32'h3C3F_FFF0, 0, 1, 0, 0);
    put_addr(32'h3C00_0000, 1, 1, 0, 0);
    run_cmd(1, 32'h3C3F_FFF0, 3, "R2");
    cmp_all("R2 window edge");

    // R3: unaligned start and zero count
    line_sel = 1'b1; size_sel = 1'b0;
    put_addr(32'h3C00_1240, 0, 1, 0, 0);
    put_addr(32'h3C00_1260, 1, 1, 0, 0);
    run_cmd(1, 32'h3C00_125F, 1, "R3");
    cmp_all("R3 aligned start");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 32'h3C00_1260; cmd_items = '0;
    @(negedge clk); cmd_valid = 1'b0;
    check(busy_o === 1'b0, "R3 zero count busy", {31'd0, busy_o}, 32'd0);
    cmp_all("R3 zero count");

    // R4: locked entry survives invalidate; R7 unlock then invalidate
    put_addr(32'h3C01_0000, 2, 1, 1, 1);
    run_cmd(1, 32'h3C01_0000, 1, "R4");
    cmp_all("R4 locked kept");
    run_cmd(5, 32'h3C01_0000, 1, "R7");
    run_cmd(1, 32'h3C01_0000, 1, "R4");
    cmp_all("R7 unlock then invalidate");

    // R5: clean, explicit bit check, no request
    put_addr(32'h3C02_0040, 3, 1, 1, 0);
    a = mdl[3][set_of(32'h3C02_0040)];
    run_cmd(2, 32'h3C02_0040, 1, "R5");
    @(negedge clk); tr_en = 1'b1; tr_set = 8'(set_of(32'h3C02_0040)); tr_way = 2'd3;
    @(negedge clk); tr_en = 1'b0;
    check(tr_data === (a & ~32'd1), "R5 R1 dirty bit 0 cleared", tr_data, a & ~32'd1);

    // R9: duplicate tag, lowest way locked
    put_addr(32'h3C03_0100, 1, 1, 0, 0);
    put_addr(32'h3C03_0100, 2, 1, 0, 0);
    run_cmd(4, 32'h3C03_0100, 1, "R7");
    cmp_all("R9 lowest way");

    // R11: command while busy dropped, error pulse
    for (int k = 0; k < 20; k++) put_addr(32'h3C04_0000 + 32'(k * 32), k % 4, 1, 1, 0);
    model(2, 32'h3C04_0000, 20);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = 32'h3C04_0000; cmd_items = 19'd20;
    @(negedge clk);
    cmd_op = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(err_o === 1'b1, "R11 error pulse", {31'd0, err_o}, 32'd1);
    @(negedge clk);
    check(err_o === 1'b0, "R11 error one cycle", {31'd0, err_o}, 32'd0);
    while (busy_o) @(negedge clk);
    cmp_all("R11 second command dropped");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7; cmd_addr = 32'h3C04_0000; cmd_items = 19'd4;
    @(negedge clk); cmd_valid = 1'b0;
    check(busy_o === 1'b0, "R11 illegal op", {31'd0, busy_o}, 32'd0);

    // R6: writeback with dirty and clean hits
    line_sel = 1'b0; size_sel = 1'b0;
    for (int k = 0; k < 8; k++) put_addr(32'h3C05_0000 + 32'(k * 16), k % 4, 1, k % 2, 0);
    run_cmd(3, 32'h3C05_0000, 8, "R6");
    cmp_all("R6 dirty cleared");

    // R8: invalidate all including locked
    put_addr(32'h3C06_0000, 0, 1, 1, 1);
    run_cmd(6, 32'h0, 0, "R8");
    cmp_all("R8 all invalid");

    // random mixes
    for (int it = 0; it < 14; it++) begin
      line_sel = 1'($urandom); size_sel = 1'($urandom);
      lbytes = 1 << lb_of();
      st_a = 32'h3C00_0000 | ($urandom & 32'h003F_FFFF);
      items = 1 + $urandom % 24;
      for (int k = 0; k < items + 4; k++) begin
        a = st_a + ($urandom % (items * lbytes + 32));
        put_addr(a, $urandom % 4, ($urandom % 4) != 0, 1'($urandom), ($urandom % 4) == 0);
      end
      for (int k = 0; k < 4; k++)
        put_addr(32'h3C00_0000 | ($urandom & 32'h003F_FFFF), $urandom % 4, 1, 1'($urandom), 0);
      op = ($urandom % 8 == 0) ? 6 : 1 + $urandom % 5;
      run_cmd(op, st_a, items, "random");
      cmp_all($sformatf("random op %0d R2 R4 R5 R7 R9", op));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule